// File: doc/BRIEF.md
# Dual-Select Static Word Memory

This block is a synthesizable model of an asynchronous-style static word memory. The control pins are sampled on a fast internal clock. The memory is organised as 2^(LO_W+1) words of 24 bits. The address is built from a LO_W-bit low field and one top bit. The top bit comes from one of two alternative pins, and a source-select input chooses which pin is used. The memory is enabled only when an active-low select is low and an active-high select is high. An active-low output enable and an active-low write enable then choose among read, write and output-off behaviour. A deselected memory stays in standby.

A write lasts for as long as both selects are active and the write enable is low. Each clock sample inside that window captures the address and data, so the last sample wins. The captured word is committed at the first sample after any one of the three signals drops out. Reads return data one clock after the sampled request. A data-valid flag stands in for the tri-state drivers, and the data bus reads as zero whenever that flag is low. Memory contents are undefined after power-up. With the default LO_W of 9 the array holds 1,024 words. Setting LO_W to 15 gives the full 65,536-word organisation.

Top module: `dual_sel_sram`

## Requirements
- R1: The array holds 2^(LO_W+1) words of 24 bits each. The full word address is {top bit, addr_lo}, and both halves of the address space store words independently.
- R2: The memory is selected only when cs1_n is 0 and cs2 is 1. With any other combination, rdata_en is 0 one cycle later and no word is written.
- R3: When hi_src_sel is 1, the top address bit is taken from addr_hi_b. When hi_src_sel is 0, it is taken from addr_hi_a. The unselected pin has no effect.
- R4: A read is requested when the memory is selected, oe_n is 0 and we_n is 1. One cycle after that sample, rdata_en is 1 and rdata holds the word stored at the sampled address.
- R5: A write is accepted whenever the memory is selected and we_n is 0, whether oe_n is 0 or 1.
- R6: When the memory is selected and both oe_n and we_n are 1, rdata_en is 0 one cycle later.
- R7: The write window is the overlap of cs1_n at 0, cs2 at 1 and we_n at 0. The window ends when any one of these three signals becomes inactive. The word stored is the address and data of the last sample taken inside the window, and it is committed at the first sample outside the window.
- R8: While a write window is open, rdata_en is 0 one cycle later, even if oe_n is 0.
- R9: A read sampled in the same cycle that a write commits, at the same address, returns the newly committed word.
- R10: Whenever rdata_en is 0, rdata is all zeros.
- R11: A synchronous active-low reset (rst_n) sets rdata_en and rdata to 0 and discards a write whose window has not yet closed. Stored words are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_lo | input | LO_W | Low address field |
| addr_hi_a | input | 1 | Top address bit source used when hi_src_sel is 0 |
| addr_hi_b | input | 1 | Top address bit source used when hi_src_sel is 1 |
| hi_src_sel | input | 1 | Chooses the source of the top address bit |
| cs1_n | input | 1 | Active-low select |
| cs2 | input | 1 | Active-high select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Read data, zero when not driven |
| rdata_en | output | 1 | High when the model would drive its data pins |

## Verification
The bench closes write windows with each of the three signals in turn. A design that watches only we_n would then never commit writes that a select ends. It also changes the address and data in the middle of an open window, which exposes a design that keeps the first sample instead of the last. It puts the opposite value on the unused top-address pin for every access, so a swapped source select corrupts the wrong half of the array. Other cases cover a read of the same word in the commit cycle, a write made with oe_n low, and a reset that arrives while a window is open. A design that got these wrong would return stale data, drive during a write, or commit a write that was abandoned.

// File: rtl/dual_sel_sram_pkg.sv
// Shared types for the dual-select memory model.
package dual_sel_sram_pkg;
    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_READ    = 2'd1,
        MODE_WRITE   = 2'd2,
        MODE_OUT_OFF = 2'd3
    } access_mode_e;
endpackage

// File: rtl/dsr_addr_mux.sv
// Builds the full word address from the low field and one of two top-bit pins.
// Assumes the pins are stable around the sampling edge; purely combinational.
module dsr_addr_mux #(
    parameter int LO_W = 9,
    localparam int AW  = LO_W + 1
) (
    input  logic [LO_W-1:0] addr_lo,
    input  logic            addr_hi_a,
    input  logic            addr_hi_b,
    input  logic            hi_src_sel,
    output logic [AW-1:0]   full_addr
);
    logic top_bit;

    // Pick the source pin of the top address bit.
    always_comb top_bit = hi_src_sel ? addr_hi_b : addr_hi_a;

    // Concatenate the top bit above the low field.
    always_comb full_addr = {top_bit, addr_lo};
endmodule

// File: rtl/dsr_mode_decode.sv
// Decodes the select, output-enable and write-enable pins into one access mode.
// Assumes active-low cs1_n and we_n/oe_n, active-high cs2; combinational.
module dsr_mode_decode
    import dual_sel_sram_pkg::*;
(
    input  logic         cs1_n,
    input  logic         cs2,
    input  logic         oe_n,
    input  logic         we_n,
    output access_mode_e mode
);
    // Selection gates everything; write wins over output enable.
    always_comb begin
        if (cs1_n || !cs2)  mode = MODE_STANDBY;
        else if (!we_n)     mode = MODE_WRITE;
        else if (!oe_n)     mode = MODE_READ;
        else                mode = MODE_OUT_OFF;
    end
endmodule

// File: rtl/dsr_write_window.sv
// Tracks the write window: latches address and data on every sample inside it
// and issues a one-cycle commit on the first sample after it closes.
// Assumes a synchronous active-low reset that abandons an open window.
module dsr_write_window
    import dual_sel_sram_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  access_mode_e  mode,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          commit,
    output logic [AW-1:0] commit_addr,
    output logic [DW-1:0] commit_data
);
    logic          pend_valid;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_data;
    logic          in_window;

    // The window is open while the decoded mode is a write.
    always_comb in_window = (mode == MODE_WRITE);

    // Latch the newest sample inside the window; clear once it has committed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_data  <= '0;
        end else if (in_window) begin
            pend_valid <= 1'b1;
            pend_addr  <= addr;
            pend_data  <= wdata;
        end else if (pend_valid) begin
            pend_valid <= 1'b0;
        end
    end

    // Commit on the first sample outside the window, never during reset.
    always_comb begin
        commit      = rst_n && pend_valid && !in_window;
        commit_addr = pend_addr;
        commit_data = pend_data;
    end

    // R7: every sample inside the window leaves a pending word behind.
    assert_window_latches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_window |=> pend_valid);

    // R7: a pending word is committed exactly once when the window closes.
    assert_commit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && !in_window) |=> !pend_valid);
endmodule

// File: rtl/dsr_store.sv
// Word array with one write port and one combinational read port.
// The read port forwards a same-cycle commit to the same address.
// Contents are undefined after power-up; the array has no reset.
module dsr_store #(
    parameter int AW = 10,
    parameter int DW = 24,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] words [DEPTH];

    // Store the committed word.
    always_ff @(posedge clk) begin
        if (wr_en) words[wr_addr] <= wr_data;
    end

    // Read the array, forwarding a commit that lands in the same cycle.
    always_comb begin
        if (wr_en && (wr_addr == rd_addr)) rd_data = wr_data;
        else                               rd_data = words[rd_addr];
    end
endmodule

// File: rtl/dual_sel_sram.sv
// Top of the dual-select static memory model. It samples the asynchronous-style
// pins on clk, decodes the access mode and runs the write window. It registers
// read data and a drive flag that stands in for tri-state output.
// Assumes all pins are synchronous to clk; the reset is synchronous active-low.
module dual_sel_sram
    import dual_sel_sram_pkg::*;
#(
    parameter int LO_W = 9,
    parameter int DW   = 24,
    localparam int AW  = LO_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LO_W-1:0] addr_lo,
    input  logic            addr_hi_a,
    input  logic            addr_hi_b,
    input  logic            hi_src_sel,
    input  logic            cs1_n,
    input  logic            cs2,
    input  logic            oe_n,
    input  logic            we_n,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            rdata_en
);
    logic [AW-1:0] full_addr;
    access_mode_e  mode;
    logic          commit;
    logic [AW-1:0] commit_addr;
    logic [DW-1:0] commit_data;
    logic [DW-1:0] rd_word;

    dsr_addr_mux #(.LO_W(LO_W)) u_mux (
        .addr_lo    (addr_lo),
        .addr_hi_a  (addr_hi_a),
        .addr_hi_b  (addr_hi_b),
        .hi_src_sel (hi_src_sel),
        .full_addr  (full_addr)
    );

    dsr_mode_decode u_dec (
        .cs1_n (cs1_n),
        .cs2   (cs2),
        .oe_n  (oe_n),
        .we_n  (we_n),
        .mode  (mode)
    );

    dsr_write_window #(.AW(AW), .DW(DW)) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .addr        (full_addr),
        .wdata       (wdata),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data)
    );

    dsr_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .wr_en   (commit),
        .wr_addr (commit_addr),
        .wr_data (commit_data),
        .rd_addr (full_addr),
        .rd_data (rd_word)
    );

    // Register the drive flag and the data, which reads as zero when not driven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_en <= 1'b0;
            rdata    <= '0;
        end else if (mode == MODE_READ) begin
            rdata_en <= 1'b1;
            rdata    <= rd_word;
        end else begin
            rdata_en <= 1'b0;
            rdata    <= '0;
        end
    end

    // R2: a deselected sample never drives on the next cycle.
    assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs1_n || !cs2) |=> !rdata_en);

    // R6: selected with both enables high leaves the outputs off.
    assert_out_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs1_n && cs2 && oe_n && we_n) |=> !rdata_en);

    // R8: no drive follows a sample with the write window open.
    assert_no_drive_in_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs1_n && cs2 && !we_n) |=> !rdata_en);

    // R10: data bus is zero whenever the drive flag is low.
    assert_zero_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_en |-> (rdata == '0));
endmodule

// File: tb/dual_sel_sram_tb_top.sv
module dual_sel_sram_tb_top;
    localparam int LO_W = 9;
    localparam int AW   = LO_W + 1;
    localparam int DW   = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [LO_W-1:0] addr_lo = '0;
    logic            addr_hi_a = 1'b0;
    logic            addr_hi_b = 1'b0;
    logic            hi_src_sel = 1'b0;
    logic            cs1_n = 1'b1;
    logic            cs2 = 1'b0;
    logic            oe_n = 1'b1;
    logic            we_n = 1'b1;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic            rdata_en;

    int n_checks = 0;
    int n_fails  = 0;
    string tag = "R11";

    // Reference model state.
    logic [DW-1:0] ref_mem [int];
    bit            p_v = 0;
    int            p_a = 0;
    logic [DW-1:0] p_d = '0;
    bit            e_en = 0;
    bit            e_known = 0;
    logic [DW-1:0] e_d = '0;

    always #10 clk = ~clk;

    dual_sel_sram #(.LO_W(LO_W), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_lo(addr_lo), .addr_hi_a(addr_hi_a),
        .addr_hi_b(addr_hi_b), .hi_src_sel(hi_src_sel), .cs1_n(cs1_n), .cs2(cs2),
        .oe_n(oe_n), .we_n(we_n), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
    );

    task automatic model_step();
        int  fa;
        bit  hi, win, rd;
        if (!rst_n) begin
            e_en = 0; e_known = 0; e_d = '0; p_v = 0;
        end else begin
            hi  = hi_src_sel ? addr_hi_b : addr_hi_a;
            fa  = {hi, addr_lo};
            win = !cs1_n && cs2 && !we_n;
            rd  = !cs1_n && cs2 && !oe_n && we_n;
            if (win) begin
                p_v = 1; p_a = fa; p_d = wdata;
            end else if (p_v) begin
                ref_mem[p_a] = p_d; p_v = 0;
            end
            e_en = rd;
            e_known = rd && ref_mem.exists(fa);
            e_d = e_known ? ref_mem[fa] : '0;
        end
    endtask

    task automatic compare();
        n_checks++;
        if (rdata_en !== e_en) begin
            n_fails++;
            $display("FAIL %s rdata_en actual=%0b expected=%0b", tag, rdata_en, e_en);
        end
        if (!e_en) begin
            n_checks++;
            if (rdata !== '0) begin
                n_fails++;
                $display("FAIL R10 (%s) rdata actual=%06h expected=000000", tag, rdata);
            end
        end else if (e_known) begin
            n_checks++;
            if (rdata !== e_d) begin
                n_fails++;
                $display("FAIL %s rdata actual=%06h expected=%06h", tag, rdata, e_d);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        cs1_n = 1; cs2 = 0; oe_n = 1; we_n = 1;
        tick();
    endtask

    task automatic put_addr(input int fa, input bit sel);
        bit hi;
        hi = fa[AW-1];
        hi_src_sel = sel;
        addr_lo = fa[LO_W-1:0];
        addr_hi_a = sel ? ~hi : hi;
        addr_hi_b = sel ? hi : ~hi;
    endtask

    // term: 0 ends via we_n, 1 via cs1_n, 2 via cs2. The first sample is a decoy.
    task automatic do_write(input int fa, input logic [DW-1:0] d, input bit sel,
                            input int term, input bit oe);
        put_addr(fa ^ 1, sel); wdata = ~d;
        cs1_n = 0; cs2 = 1; oe_n = oe; we_n = 0;
        tick();
        put_addr(fa, sel); wdata = d;
        tick();
        case (term)
            1:       cs1_n = 1;
            2:       cs2 = 0;
            default: we_n = 1;
        endcase
        oe_n = 1; wdata = 24'h5A5A5A;
        tick();
        cs1_n = 1; cs2 = 0; we_n = 1;
    endtask

    task automatic do_read(input int fa, input bit sel);
        put_addr(fa, sel);
        cs1_n = 0; cs2 = 1; oe_n = 0; we_n = 1;
        tick();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        tag = "R11"; rst_n = 0;
        tick(); tick();
        rst_n = 1;
        idle();

        // R3 / R1: both halves, both top-bit sources, opposite level on the unused pin.
        tag = "R7";
        do_write(10'h005, 24'h111111, 0, 0, 1);
        do_write(10'h205, 24'h222222, 1, 0, 1);
        do_write(10'h00A, 24'h333333, 1, 1, 1);   // ended by cs1_n
        do_write(10'h20A, 24'h444444, 0, 2, 1);   // ended by cs2
        tag = "R3"; do_read(10'h005, 1); do_read(10'h205, 0);
        tag = "R1"; do_read(10'h00A, 0); do_read(10'h20A, 1);
        tag = "R4"; do_read(10'h205, 1); do_read(10'h005, 0);

        // R5 / R8: write with oe_n held low never drives and still stores.
        tag = "R8";
        do_write(10'h033, 24'hABCDEF, 0, 0, 0);
        tag = "R5"; do_read(10'h033, 0);

        // R6: output off while selected.
        tag = "R6";
        put_addr(10'h033, 0); cs1_n = 0; cs2 = 1; oe_n = 1; we_n = 1; tick();

        // R2: every deselect combination, with a write attempt that must not land.
        tag = "R2";
        put_addr(10'h033, 0); oe_n = 0; we_n = 1;
        cs1_n = 1; cs2 = 1; tick();
        cs1_n = 0; cs2 = 0; tick();
        cs1_n = 1; cs2 = 0; tick();
        wdata = 24'h000BAD; we_n = 0; cs1_n = 1; cs2 = 1; tick();
        cs1_n = 0; cs2 = 0; tick();
        we_n = 1; idle();
        do_read(10'h033, 0);

        // R9: read issued in the commit cycle of the same word.
        tag = "R9";
        put_addr(10'h077, 0); wdata = 24'h777777;
        cs1_n = 0; cs2 = 1; oe_n = 1; we_n = 0; tick();
        oe_n = 0; we_n = 1; tick();
        idle();

        // R11: reset during an open window abandons the pending word.
        tag = "R11";
        do_write(10'h0C0, 24'hC0FFEE, 0, 0, 1);
        put_addr(10'h0C0, 0); wdata = 24'hDEAD00;
        cs1_n = 0; cs2 = 1; oe_n = 1; we_n = 0; tick();
        rst_n = 0; tick();
        rst_n = 1; we_n = 1; tick();
        do_read(10'h0C0, 0);
        idle();

        // Mixed random traffic over a few addresses.
        tag = "R7";
        for (int i = 0; i < 400; i++) begin
            int pick;
            pick = $urandom_range(0, 3);
            put_addr(pick * 64 + (pick[0] ? 10'h200 : 0), $urandom_range(0, 1));
            cs1_n = ($urandom_range(0, 7) == 0);
            cs2   = ($urandom_range(0, 7) != 0);
            oe_n  = $urandom_range(0, 1);
            we_n  = ($urandom_range(0, 2) != 0);
            wdata = DW'($urandom);
            tick();
        end
        idle();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule